// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This controller takes a clock generator into and out of its low-power state. An active-low power-down request arrives asynchronously. It is synchronized to the fast internal clock. The controller then parks the output clock groups low in a fixed order: first the fast groups (processor and bus clocks), then the slow groups (reference and fixed-frequency clocks). Only after every group has acknowledged that it is parked low does it drop the enables of the VCO and the crystal oscillator.

On wake-up, the oscillator and VCO enables return at once. The outputs stay parked while a stabilization timer counts rising edges of the slow reference clock. When the timer finishes, all groups are released together. A new power-down request during the wait sends the controller straight back to the oscillator-off state. Stop requests from other power-management inputs have no effect on this block.

States and transitions:
- `RUN`: running. A request moves it to `PARK_FAST`.
- `PARK_FAST`: all fast acknowledges high moves it to `PARK_SLOW`.
- `PARK_SLOW`: all slow acknowledges high moves it to `OSC_OFF`.
- `OSC_OFF`: the request withdrawn moves it to `WAKE_WAIT`.
- `WAKE_WAIT`: a request moves it back to `OSC_OFF`. The last timer tick moves it to `RUN`.

Top module: `pds_ctrl`

## Requirements
- R1: After reset, every hold-low output is 0, and `vco_en` and `xtal_en` are 1.
- R2: `pd_n` passes through a two-stage synchronizer. The fast hold-low bits all become 1 at the falling clock edge that follows the third rising edge after `pd_n` goes low.
- R3: The slow hold-low bits stay 0 while any bit of `fast_low_ack` is 0. They become 1 at the first rising edge after all fast acknowledge bits are 1.
- R4: `vco_en` and `xtal_en` stay 1 while any bit of `slow_low_ack` is 0. They become 0 at the first rising edge after all slow acknowledge bits are 1, and are never 0 while any hold-low bit is 0.
- R5: In the oscillator-off state, a rise of `pd_n` sets `vco_en` and `xtal_en` to 1 at the third rising edge after the rise. All hold-low bits stay 1.
- R6: In the wake wait, the hold-low outputs are released only after `WAKE_TICKS` rising edges of `ref_clk` have been counted. The slow bits clear at a rising edge, and the fast bits clear at the next falling edge.
- R7: A fall of `pd_n` during the wake wait drops `vco_en` and `xtal_en` at the third rising edge after the fall, with no new parking step. The following wake wait counts the full `WAKE_TICKS` again.
- R8: A rise of `pd_n` while parking is in progress does not cut the sequence short. The enables still go to 0 for at least one cycle after all groups are parked.
- R9: `stop_req` has no effect on any output in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, sampled for the wake timer |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| stop_req | input | STOP_W | Stop requests, ignored |
| fast_low_ack | input | FAST_GROUPS | Per fast group: output is parked low |
| slow_low_ack | input | SLOW_GROUPS | Per slow group: output is parked low |
| hold_fast | output | FAST_GROUPS | Hold-low control per fast group, changes on falling edges |
| hold_slow | output | SLOW_GROUPS | Hold-low control per slow group |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
A state register stuck in or skipping a state shows up at the ports quickly. Either the hold-low bits move out of order, or the enables drop before every group is parked. These errors appear within one or two cycles of the acknowledge that should have advanced the sequence.

A fault in the wake timer moves the release of the hold-low outputs outside a window of about one reference period around `WAKE_TICKS` reference cycles. A wrong re-entry path shows as the enables failing to drop three cycles after a renewed request.

// File: rtl/pds_pkg.sv
package pds_pkg;
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_PARK_FAST = 3'd1,
        ST_PARK_SLOW = 3'd2,
        ST_OSC_OFF   = 3'd3,
        ST_WAKE_WAIT = 3'd4
    } pds_state_e;
endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pds_ref_tick.sv
module pds_ref_tick #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic tick
);
    logic ref_s;
    logic ref_prev_q;

    pds_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ref_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ref_clk),
        .dout (ref_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_prev_q <= 1'b0;
        else        ref_prev_q <= ref_s;
    end

    assign tick = ref_s & ~ref_prev_q;

    // R6: a tick lasts one cycle
    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pds_wake_timer.sv
module pds_wake_timer #(
    parameter int WAKE_TICKS = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(WAKE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run)            cnt_q <= '0;
        else if (tick && !done)   cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && tick && (cnt_q == LAST);

    p_count_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(WAKE_TICKS));
    p_idle_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
    import pds_pkg::*;
#(
    parameter int FAST_GROUPS = 2,
    parameter int SLOW_GROUPS = 2,
    parameter int STOP_W      = 1,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_TICKS  = 40000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_clk,
    input  logic                   pd_n,
    input  logic [STOP_W-1:0]      stop_req,
    input  logic [FAST_GROUPS-1:0] fast_low_ack,
    input  logic [SLOW_GROUPS-1:0] slow_low_ack,
    output logic [FAST_GROUPS-1:0] hold_fast,
    output logic [SLOW_GROUPS-1:0] hold_slow,
    output logic                   vco_en,
    output logic                   xtal_en
);
    pds_state_e state_q, state_d;
    logic pd_n_s;
    logic pd_req;
    logic ref_tick;
    logic wake_done;
    logic fast_parked;
    logic slow_parked;
    logic [FAST_GROUPS-1:0] hold_fast_q;

    pds_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pd_n),
        .dout (pd_n_s)
    );
    assign pd_req = ~pd_n_s;

    pds_ref_tick #(.STAGES(SYNC_STAGES)) u_ref_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_clk(ref_clk),
        .tick   (ref_tick)
    );

    pds_wake_timer #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_WAKE_WAIT),
        .tick (ref_tick),
        .done (wake_done)
    );

    assign fast_parked = &fast_low_ack;
    assign slow_parked = &slow_low_ack;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (pd_req)      state_d = ST_PARK_FAST;
            ST_PARK_FAST: if (fast_parked) state_d = ST_PARK_SLOW;
            ST_PARK_SLOW: if (slow_parked) state_d = ST_OSC_OFF;
            ST_OSC_OFF:   if (!pd_req)     state_d = ST_WAKE_WAIT;
            ST_WAKE_WAIT: begin
                if (pd_req)         state_d = ST_OSC_OFF;
                else if (wake_done) state_d = ST_RUN;
            end
            default:                       state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // fast groups park on the falling edge that follows a state change
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hold_fast_q <= '0;
        else        hold_fast_q <= {FAST_GROUPS{state_q != ST_RUN}};
    end

    always_comb begin
        hold_fast = hold_fast_q;
        hold_slow = '0;
        vco_en    = 1'b1;
        unique case (state_q)
            ST_RUN, ST_PARK_FAST: begin
                hold_slow = '0;
                vco_en    = 1'b1;
            end
            ST_PARK_SLOW, ST_WAKE_WAIT: begin
                hold_slow = '1;
                vco_en    = 1'b1;
            end
            ST_OSC_OFF: begin
                hold_slow = '1;
                vco_en    = 1'b0;
            end
            default: begin
                hold_slow = '0;
                vco_en    = 1'b1;
            end
        endcase
    end
    assign xtal_en = vco_en;

    p_slow_after_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold_slow) |-> (&hold_fast));
    p_osc_off_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_en |-> ((&hold_fast) && (&hold_slow)));
    p_fast_released_after_slow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_slow[0]) |=> (hold_fast == '0));
    p_rewait_to_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE_WAIT && pd_req) |=> (state_q == ST_OSC_OFF));
    p_park_not_aborted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK_SLOW && slow_parked) |=> !vco_en);
    p_stop_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSC_OFF && pd_req && $changed(stop_req)) |=> !xtal_en);
endmodule

// File: tb/pds_ctrl_tb.sv
module pds_ctrl_tb;
    localparam int FG = 2;
    localparam int SG = 2;
    localparam int WT = 6;
    localparam int REF_DIV = 10;

    logic clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b1;
    logic [0:0] stop_req = '0;
    logic [FG-1:0] fast_low_ack = '0;
    logic [SG-1:0] slow_low_ack = '0;
    logic [FG-1:0] hold_fast;
    logic [SG-1:0] hold_slow;
    logic vco_en, xtal_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pds_ctrl #(.FAST_GROUPS(FG), .SLOW_GROUPS(SG), .STOP_W(1), .WAKE_TICKS(WT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .pd_n(pd_n), .stop_req(stop_req),
        .fast_low_ack(fast_low_ack), .slow_low_ack(slow_low_ack),
        .hold_fast(hold_fast), .hold_slow(hold_slow), .vco_en(vco_en), .xtal_en(xtal_en)
    );

    always #2 clk = ~clk;
    always #(2 * REF_DIV) ref_clk = ~ref_clk;

    function automatic int wake_min();
        return (WT - 1) * REF_DIV;
    endfunction
    function automatic int wake_max();
        return (WT + 1) * REF_DIV + 6;
    endfunction
    function automatic logic [3:0] pack(logic [FG-1:0] f, logic [SG-1:0] s, logic v, logic x);
        return {&f ? 1'b1 : (|f ? 1'bx : 1'b0), &s ? 1'b1 : (|s ? 1'bx : 1'b0), v, x};
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] outs();
        return pack(hold_fast, hold_slow, vco_en, xtal_en);
    endfunction

    task automatic park(bit withdraw);
        logic [FG-1:0] pf;
        logic [SG-1:0] ps;
        pd_n = 1'b0;
        tick(3);
        chk("R2 before fall edge", outs(), 4'b0011);
        #2;
        chk("R2 fast parked", outs(), 4'b1011);
        if (withdraw) pd_n = 1'b1;
        pf = FG'($urandom_range(0, (1 << FG) - 2));
        fast_low_ack = pf;
        tick(1 + $urandom_range(0, 4));
        chk("R3 partial fast ack", outs(), 4'b1011);
        fast_low_ack = '1;
        tick(1);
        chk("R3 slow parked", outs(), 4'b1111);
        ps = SG'($urandom_range(0, (1 << SG) - 2));
        slow_low_ack = ps;
        tick(1 + $urandom_range(0, 4));
        chk("R4 partial slow ack", outs(), 4'b1111);
        slow_low_ack = '1;
        tick(1);
        chk(withdraw ? "R8 osc off despite withdraw" : "R4 osc off", outs(), 4'b1100);
    endtask

    task automatic wake_measure();
        int cyc = 0;
        while (hold_slow !== '0 && cyc < 400) begin
            tick(1);
            cyc++;
        end
        n_chk++;
        if (cyc < wake_min() || cyc > wake_max()) begin
            n_fail++;
            $display("FAIL R6 wake length: actual %0d expected %0d..%0d", cyc, wake_min(), wake_max());
        end
        chk("R6 fast held past slow release", outs(), 4'b1011);
        #2;
        chk("R6 all released", outs(), 4'b0011);
        fast_low_ack = '0;
        slow_low_ack = '0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        tick(3);
        chk("R1 reset state", outs(), 4'b0011);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after reset", outs(), 4'b0011);
        for (int it = 0; it < 6; it++) begin
            park(it == 3);
            if (it == 3) begin
                tick(1);
                chk("R8 wakes after withdraw", outs(), 4'b1111);
            end else begin
                for (int k = 0; k < 4; k++) begin
                    stop_req = ~stop_req;
                    tick(1);
                    chk("R9 stop ignored", outs(), 4'b1100);
                end
                pd_n = 1'b1;
                tick(2);
                chk("R5 still off", outs(), 4'b1100);
                tick(1);
                chk("R5 enables back", outs(), 4'b1111);
                if (it % 2 == 1) begin
                    tick($urandom_range(2, WT * REF_DIV / 2));
                    pd_n = 1'b0;
                    tick(3);
                    chk("R7 back to osc off", outs(), 4'b1100);
                    pd_n = 1'b1;
                    tick(3);
                    chk("R7 wake again", outs(), 4'b1111);
                end
            end
            wake_measure();
            tick($urandom_range(1, 8));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule